// File: doc/BRIEF.md
# 16-bit Host DWORD Access Adapter

This block sits between a host bus that can run 16 or 32 bits wide and an internal port that always moves whole 32-bit words. When the host runs 32 bits wide every access passes straight through. When it runs 16 bits wide the adapter pairs two half-word accesses into one internal transfer. A write is held until its partner half arrives. A read fetches the whole internal word once and hands it back in two halves from a saved copy.

The host may touch the two halves in either order. The adapter remembers which half came first and which DWORD it belongs to. An access to the same half a second time cancels the pending transfer. A move to a different DWORD cancels it as well. A local swap-control register, placed at one DWORD address, decides which internal half the host's A1 line reaches. The mapping is reversed only when that register holds all ones.

The internal handshake is one cycle long. A read strobe and its address are driven in the same cycle as the host access, and the returned word is taken in that cycle. A write strobe, its address and its data are registered and appear in the cycle after the access that completes the DWORD.

Top module: `hbus_dword_adapter`

## Requirements
- R1: In 32-bit mode (mode16=0) a host write drives int_wr_en for one cycle, in the cycle after the access, with int_wr_addr equal to host_addr[ADDR_W-1:2] and int_wr_data equal to host_wdata. host_wdata[31:16] lands in the high half whatever the swap register holds.
- R2: In 32-bit mode a host read raises int_rd_en in the same cycle with int_rd_addr = host_addr[ADDR_W-1:2]. In the next cycle host_rdata carries the full fetched word, and host_rd_valid, host_oe_lo and host_oe_hi are all 1.
- R3: In 16-bit mode an internal write is issued only after two writes to opposite halves (A1 = host_addr[1] differs) of the same DWORD, in either order. It appears in the cycle after the second write and holds the two 16-bit values host_wdata[15:0] in their mapped halves.
- R4: In 16-bit mode a second write to the half already written issues no internal write and drops the pending data. The next write counts as a first half.
- R5: In 16-bit mode the first read half raises int_rd_en and saves the whole word. The opposite second half raises no int_rd_en and returns data from the saved word, even if the internal word has changed since. Read data sits in host_rdata[15:0].
- R6: In 16-bit mode a second read of the half already read raises no int_rd_en. It returns host_rd_bad=1 with host_rdata=0, and the next read starts a fresh DWORD with a new fetch.
- R7: A change of host_addr[ADDR_W-1:2] between the two halves drops the partial read or write, and the new access counts as a first half.
- R8: With the swap register at 0xFFFFFFFF in 16-bit mode, A1=0 reaches the high half (bits 31:16) and A1=1 reaches the low half.
- R9: With any other swap-register value, A1=0 reaches the low half (bits 15:0) and A1=1 reaches the high half.
- R10: The swap register resets to 0 and sits at DWORD address SWAP_DW. It is written and read through the same 32-bit or half-pair accesses as any other word, and accesses to it raise neither int_wr_en nor int_rd_en.
- R11: In 16-bit mode read data never drives the upper pins: host_oe_hi stays 0 and host_rdata[31:16] is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode16 | input | 1 | 1 selects the 16-bit host bus, 0 the 32-bit bus |
| host_cs | input | 1 | One host access in this cycle |
| host_we | input | 1 | 1 for a write access, 0 for a read |
| host_addr | input | ADDR_W-1 | Host byte address bits ADDR_W-1 down to 1; bit 1 is A1 |
| host_wdata | input | 32 | Host write data (bits 15:0 only in 16-bit mode) |
| host_rdata | output | 32 | Read data, valid with host_rd_valid |
| host_rd_valid | output | 1 | Read data returned, one cycle after a read access |
| host_rd_bad | output | 1 | Returned half is invalid because the same half was read twice |
| host_oe_hi | output | 1 | Output enable for data bits 31:16 |
| host_oe_lo | output | 1 | Output enable for data bits 15:0 |
| int_rd_en | output | 1 | Internal read strobe, same cycle as the host access |
| int_rd_addr | output | ADDR_W-2 | Internal DWORD read address |
| int_rdata | input | 32 | Internal read word, sampled in the int_rd_en cycle |
| int_wr_en | output | 1 | Internal write strobe |
| int_wr_addr | output | ADDR_W-2 | Internal DWORD write address |
| int_wr_data | output | 32 | Internal write word |

## Verification
The pairing state and the swap flag are invisible by themselves, but any error in them reaches the ports within one access. If the stored half is wrong, an internal write appears after a repeated half, or goes missing after a proper pair. If the stored DWORD tag is wrong, a write lands at the wrong int_wr_addr. If the saved read word is wrong, the second read half returns a value that differs from the word fetched with the first half. The bench changes the internal word between the two halves so that a fresh fetch and a saved copy give different data. A wrong swap decision puts a half in the wrong position of int_wr_data in the cycle after the pair completes, and the bench checks both swap settings and an almost-all-ones value.

// File: rtl/hda_pkg.sv
package hda_pkg;

    localparam int DATA_W = 32;
    localparam int HALF_W = DATA_W / 2;

    typedef logic [HALF_W-1:0] half_word_t;
    typedef logic [DATA_W-1:0] full_word_t;

    // classification of a 16-bit access against the pending half
    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_FIRST  = 2'd1,
        ACC_SECOND = 2'd2,
        ACC_REPEAT = 2'd3
    } acc_kind_e;

    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_sel_e;

    // place the arriving half beside the held one
    function automatic full_word_t merge_halves(half_sel_e new_half,
                                                half_word_t new_w,
                                                half_word_t held_w);
        full_word_t w;
        if (new_half == HALF_HI) w = {new_w, held_w};
        else                     w = {held_w, new_w};
        return w;
    endfunction

    function automatic half_word_t pick_half(half_sel_e h, full_word_t w);
        half_word_t r;
        if (h == HALF_HI) r = w[DATA_W-1:HALF_W];
        else              r = w[HALF_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/hda_half_tracker.sv
module hda_half_tracker
    import hda_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             acc,
    input  half_sel_e        half,
    input  logic [TAG_W-1:0] tag,
    output acc_kind_e        kind
);

    typedef struct packed {
        logic             busy;
        half_sel_e        half;
        logic [TAG_W-1:0] tag;
    } track_t;

    track_t st_q;

    always_comb begin
        if (!acc)
            kind = ACC_NONE;
        else if (!st_q.busy || st_q.tag != tag)
            kind = ACC_FIRST;
        else if (st_q.half == half)
            kind = ACC_REPEAT;
        else
            kind = ACC_SECOND;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st_q <= '0;
        end else if (acc) begin
            if (kind == ACC_FIRST) begin
                st_q.busy <= 1'b1;
                st_q.half <= half;
                st_q.tag  <= tag;
            end else begin
                st_q.busy <= 1'b0;
            end
        end
    end

    // R4/R6: the same half twice in a row on one DWORD is a repeat
    a_r4_same_half_repeats: assert property (@(posedge clk) disable iff (rst)
        (acc && !clr && kind == ACC_FIRST) ##1
        (acc && !clr && tag == $past(tag) && half == $past(half))
        |-> kind == ACC_REPEAT);

    // R7: a new DWORD tag after a first half starts over
    a_r7_tag_change_restarts: assert property (@(posedge clk) disable iff (rst)
        (acc && !clr && kind == ACC_FIRST) ##1 (acc && !clr && tag != $past(tag))
        |-> kind == ACC_FIRST);

    // R3: the opposite half of the same DWORD completes the pair
    a_r3_other_half_completes: assert property (@(posedge clk) disable iff (rst)
        (acc && !clr && kind == ACC_FIRST) ##1
        (acc && !clr && tag == $past(tag) && half != $past(half))
        |-> kind == ACC_SECOND);

endmodule

// File: rtl/hda_swap_reg.sv
module hda_swap_reg
    import hda_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  full_word_t wdata,
    output full_word_t value,
    output logic       swap_on
);

    full_word_t val_q;

    always_ff @(posedge clk) begin
        if (rst)        val_q <= '0;
        else if (wr_en) val_q <= wdata;
    end

    assign value   = val_q;
    assign swap_on = (val_q == '1);

    // R10: the register comes out of reset cleared
    a_r10_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> val_q == '0);

    // R10: the value moves only on a write
    a_r10_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en)) |-> $stable(val_q));

endmodule

// File: rtl/hbus_dword_adapter.sv
module hbus_dword_adapter
    import hda_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int SWAP_DW = 63
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode16,
    input  logic              host_cs,
    input  logic              host_we,
    input  logic [ADDR_W-1:1] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              host_rd_valid,
    output logic              host_rd_bad,
    output logic              host_oe_hi,
    output logic              host_oe_lo,
    output logic              int_rd_en,
    output logic [ADDR_W-3:0] int_rd_addr,
    input  logic [31:0]       int_rdata,
    output logic              int_wr_en,
    output logic [ADDR_W-3:0] int_wr_addr,
    output logic [31:0]       int_wr_data
);

    localparam int               TAG_W    = ADDR_W - 2;
    localparam logic [TAG_W-1:0] SWAP_TAG = TAG_W'(SWAP_DW);

    // ---------------- access decode ----------------
    logic [TAG_W-1:0] tag;
    logic             a1;
    logic             swap_on;
    half_sel_e        phys;
    logic             hit_swap;
    logic             wr_acc16, rd_acc16, wr32, rd32;

    assign tag      = host_addr[ADDR_W-1:2];
    assign a1       = host_addr[1];
    assign phys     = half_sel_e'(mode16 & (a1 ^ swap_on));
    assign hit_swap = (tag == SWAP_TAG);
    assign wr_acc16 = host_cs & mode16 & host_we;
    assign rd_acc16 = host_cs & mode16 & ~host_we;
    assign wr32     = host_cs & ~mode16 & host_we;
    assign rd32     = host_cs & ~mode16 & ~host_we;

    // ---------------- half trackers ----------------
    acc_kind_e wr_kind, rd_kind;

    hda_half_tracker #(.TAG_W(TAG_W)) wr_trk_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (~mode16),
        .acc  (wr_acc16),
        .half (phys),
        .tag  (tag),
        .kind (wr_kind)
    );

    hda_half_tracker #(.TAG_W(TAG_W)) rd_trk_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (~mode16),
        .acc  (rd_acc16),
        .half (phys),
        .tag  (tag),
        .kind (rd_kind)
    );

    // ---------------- write path ----------------
    half_word_t wbuf_q;
    logic       wr_fire;
    full_word_t wr_word;
    full_word_t swap_val;

    assign wr_fire = wr32 | (wr_kind == ACC_SECOND);
    assign wr_word = mode16 ? merge_halves(phys, host_wdata[HALF_W-1:0], wbuf_q)
                            : host_wdata;

    always_ff @(posedge clk) begin
        if (rst)
            wbuf_q <= '0;
        else if (wr_kind == ACC_FIRST)
            wbuf_q <= host_wdata[HALF_W-1:0];
    end

    hda_swap_reg swap_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_fire & hit_swap),
        .wdata   (wr_word),
        .value   (swap_val),
        .swap_on (swap_on)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            int_wr_en   <= 1'b0;
            int_wr_addr <= '0;
            int_wr_data <= '0;
        end else begin
            int_wr_en <= wr_fire & ~hit_swap;
            if (wr_fire) begin
                int_wr_addr <= tag;
                int_wr_data <= wr_word;
            end
        end
    end

    // ---------------- read path ----------------
    logic       rd_fetch;
    full_word_t rd_src;
    full_word_t snap_q;
    full_word_t rd_next;
    logic       rd_was16_q;

    assign rd_fetch    = rd32 | (rd_kind == ACC_FIRST);
    assign rd_src      = hit_swap ? swap_val : int_rdata;
    assign int_rd_en   = rd_fetch & ~hit_swap;
    assign int_rd_addr = tag;

    always_comb begin
        rd_next = '0;
        if (rd32)
            rd_next = rd_src;
        else begin
            case (rd_kind)
                ACC_FIRST:  rd_next = {{HALF_W{1'b0}}, pick_half(phys, rd_src)};
                ACC_SECOND: rd_next = {{HALF_W{1'b0}}, pick_half(phys, snap_q)};
                default:    rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q        <= '0;
            host_rdata    <= '0;
            host_rd_valid <= 1'b0;
            host_rd_bad   <= 1'b0;
            rd_was16_q    <= 1'b0;
        end else begin
            if (rd_kind == ACC_FIRST)
                snap_q <= rd_src;
            host_rd_valid <= host_cs & ~host_we;
            host_rd_bad   <= (rd_kind == ACC_REPEAT);
            host_rdata    <= rd_next;
            rd_was16_q    <= mode16;
        end
    end

    assign host_oe_lo = host_rd_valid;
    assign host_oe_hi = host_rd_valid & ~rd_was16_q;

    // ---------------- assertions ----------------
    // R1/R3: an internal write always follows a host write access
    a_r3_write_has_source: assert property (@(posedge clk) disable iff (rst)
        int_wr_en |-> $past(host_cs && host_we));

    // R4: a repeated half never produces an internal write
    a_r4_repeat_no_write: assert property (@(posedge clk) disable iff (rst)
        (wr_acc16 && wr_kind == ACC_REPEAT) |=> !int_wr_en);

    // R5: the second read half is served without fetching
    a_r5_second_no_fetch: assert property (@(posedge clk) disable iff (rst)
        (rd_acc16 && rd_kind == ACC_SECOND) |-> !int_rd_en);

    // R6: a repeated read half returns a flagged zero
    a_r6_repeat_flagged: assert property (@(posedge clk) disable iff (rst)
        (rd_acc16 && rd_kind == ACC_REPEAT) |=> (host_rd_bad && host_rdata == '0));

    // R10: the swap register address never reaches the internal port
    a_r10_swap_local: assert property (@(posedge clk) disable iff (rst)
        (host_cs && hit_swap) |-> !int_rd_en);

    // R11: upper pins stay quiet for 16-bit reads
    a_r11_upper_quiet: assert property (@(posedge clk) disable iff (rst)
        (host_rd_valid && $past(mode16)) |-> (!host_oe_hi && host_rdata[31:16] == '0));

endmodule

// File: tb/hbus_dword_adapter_tb_top.sv
module hbus_dword_adapter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SWAP_DW    = 63;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode16 = 1'b0;
    logic        host_cs = 1'b0;
    logic        host_we = 1'b0;
    logic [7:1]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_rd_valid, host_rd_bad, host_oe_hi, host_oe_lo;
    logic        int_rd_en, int_wr_en;
    logic [5:0]  int_rd_addr, int_wr_addr;
    logic [31:0] int_rdata, int_wr_data;
    logic [7:0]  salt = 8'h00;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // internal memory stand-in: contents depend on address and a salt
    function automatic logic [31:0] memf(int dw, logic [7:0] s);
        logic [5:0] a;
        a = 6'(dw);
        return {2'b01, a, 8'hC3, s, 2'b10, ~a};
    endfunction

    assign int_rdata = memf(int'(int_rd_addr), salt);

    hbus_dword_adapter #(.ADDR_W(8), .SWAP_DW(SWAP_DW)) dut_i (
        .clk(clk), .rst(rst), .mode16(mode16),
        .host_cs(host_cs), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rd_valid(host_rd_valid), .host_rd_bad(host_rd_bad),
        .host_oe_hi(host_oe_hi), .host_oe_lo(host_oe_lo),
        .int_rd_en(int_rd_en), .int_rd_addr(int_rd_addr), .int_rdata(int_rdata),
        .int_wr_en(int_wr_en), .int_wr_addr(int_wr_addr), .int_wr_data(int_wr_data)
    );

    // behavioural reference state
    logic [31:0] m_swap = '0;
    int          m_wpend = -1, m_wtag = 0, m_rpend = -1, m_rtag = 0;
    logic [15:0] m_wbuf = '0;
    logic [31:0] m_snap = '0;

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic set_mode(bit m);
        @(negedge clk);
        host_cs = 1'b0;
        mode16  = m;
        m_wpend = -1;
        m_rpend = -1;
        @(posedge clk);
    endtask

    task automatic idle(string req);
        @(negedge clk);
        host_cs = 1'b0;
        @(posedge clk);
        #1;
        check(req, "idle int_wr_en", 32'(int_wr_en), 32'd0);
        check(req, "idle rd_valid", 32'(host_rd_valid), 32'd0);
    endtask

    task automatic access(bit we, int dw, bit a1, logic [31:0] d, string req);
        bit          swp, ph;
        logic [31:0] src, word, new_swap;
        bit          e_rd_en = 0, e_wr = 0, e_bad = 0;
        logic [31:0] e_rdata = '0, e_wdata = '0;
        swp = (m_swap == 32'hFFFF_FFFF);
        ph  = mode16 ? (a1 ^ swp) : 1'b0;
        src = (dw == SWAP_DW) ? m_swap : memf(dw, salt);
        new_swap = m_swap;
        if (!mode16) begin
            if (we) begin
                if (dw == SWAP_DW) new_swap = d;
                else begin e_wr = 1; e_wdata = d; end
            end else begin
                e_rd_en = (dw != SWAP_DW);
                e_rdata = src;
            end
        end else if (we) begin
            if (m_wpend < 0 || m_wtag != dw) begin
                m_wpend = int'(ph); m_wtag = dw; m_wbuf = d[15:0];
            end else if (m_wpend == int'(ph)) begin
                m_wpend = -1;
            end else begin
                word = ph ? {d[15:0], m_wbuf} : {m_wbuf, d[15:0]};
                m_wpend = -1;
                if (dw == SWAP_DW) new_swap = word;
                else begin e_wr = 1; e_wdata = word; end
            end
        end else begin
            if (m_rpend < 0 || m_rtag != dw) begin
                m_snap = src;
                e_rd_en = (dw != SWAP_DW);
                e_rdata = ph ? {16'h0, src[31:16]} : {16'h0, src[15:0]};
                m_rpend = int'(ph); m_rtag = dw;
            end else if (m_rpend == int'(ph)) begin
                e_bad = 1; e_rdata = '0; m_rpend = -1;
            end else begin
                e_rdata = ph ? {16'h0, m_snap[31:16]} : {16'h0, m_snap[15:0]};
                m_rpend = -1;
            end
        end

        @(negedge clk);
        host_cs    = 1'b1;
        host_we    = we;
        host_addr  = {6'(dw), a1};
        host_wdata = d;
        #1;
        check(req, "int_rd_en", 32'(int_rd_en), 32'(e_rd_en));
        if (e_rd_en) check(req, "int_rd_addr", 32'(int_rd_addr), 32'(dw));
        @(posedge clk);
        #1;
        m_swap = new_swap;
        check(req, "int_wr_en", 32'(int_wr_en), 32'(e_wr));
        if (e_wr) begin
            check(req, "int_wr_addr", 32'(int_wr_addr), 32'(dw));
            check(req, "int_wr_data", int_wr_data, e_wdata);
        end
        check(req, "rd_valid", 32'(host_rd_valid), 32'(!we));
        check(req, "oe_lo", 32'(host_oe_lo), 32'(!we));
        check(req, "oe_hi", 32'(host_oe_hi), 32'(!we && !mode16));
        if (!we) begin
            check(req, "rdata", host_rdata, e_rdata);
            check(req, "rd_bad", 32'(host_rd_bad), 32'(e_bad));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // reset state
        check("R2", "reset rd_valid", 32'(host_rd_valid), 32'd0);
        check("R1", "reset int_wr_en", 32'(int_wr_en), 32'd0);
        check("R11", "reset oe_hi", 32'(host_oe_hi), 32'd0);

        // R1, R2, R10 in 32-bit mode
        access(1, 5, 0, 32'h1234_5678, "R1");
        access(0, 5, 0, 32'h0, "R2");
        access(0, SWAP_DW, 0, 32'h0, "R10");
        idle("R1");

        set_mode(1);
        // R3 both orders
        access(1, 2, 0, 32'h0000_AAAA, "R3");
        access(1, 2, 1, 32'h0000_BBBB, "R3");
        access(1, 3, 1, 32'h0000_1111, "R3");
        access(1, 3, 0, 32'h0000_2222, "R3");
        // R4 repeated half
        access(1, 4, 0, 32'h0000_0101, "R4");
        access(1, 4, 0, 32'h0000_0202, "R4");
        access(1, 4, 1, 32'h0000_0303, "R4");
        access(1, 4, 0, 32'h0000_0404, "R4");
        // R7 tag change
        access(1, 6, 0, 32'h0000_0606, "R7");
        access(1, 7, 1, 32'h0000_0707, "R7");
        access(1, 7, 0, 32'h0000_0708, "R7");
        access(0, 8, 0, 32'h0, "R7");
        access(0, 9, 1, 32'h0, "R7");
        access(0, 9, 0, 32'h0, "R7");
        idle("R3");
        // R5 snapshot survives an internal change
        salt = 8'h11;
        access(0, 9, 0, 32'h0, "R5");
        salt = 8'h22;
        access(0, 9, 1, 32'h0, "R5");
        access(0, 11, 1, 32'h0, "R5");
        salt = 8'h33;
        access(0, 11, 0, 32'h0, "R5");
        // R6 repeated read half
        access(0, 10, 0, 32'h0, "R6");
        access(0, 10, 0, 32'h0, "R6");
        salt = 8'h44;
        access(0, 10, 1, 32'h0, "R6");
        access(0, 10, 0, 32'h0, "R6");
        // R9 near-all-ones value keeps the default mapping
        access(1, SWAP_DW, 0, 32'h0000_FFFF, "R10");
        access(1, SWAP_DW, 1, 32'h0000_FFFE, "R10");
        access(0, SWAP_DW, 1, 32'h0, "R10");
        access(0, SWAP_DW, 0, 32'h0, "R10");
        access(1, 12, 0, 32'h0000_0001, "R9");
        access(1, 12, 1, 32'h0000_0002, "R9");
        // R8 all ones enables swap
        access(1, SWAP_DW, 1, 32'h0000_FFFF, "R8");
        access(1, SWAP_DW, 0, 32'h0000_FFFF, "R8");
        access(1, 13, 0, 32'h0000_AAAA, "R8");
        access(1, 13, 1, 32'h0000_5555, "R8");
        access(0, 14, 0, 32'h0, "R8");
        access(0, 14, 1, 32'h0, "R8");
        access(0, SWAP_DW, 1, 32'h0, "R11");
        idle("R8");

        // R1 with swap on: 32-bit mode ignores it
        set_mode(0);
        access(1, 15, 0, 32'hDEAD_BEEF, "R1");
        access(0, 15, 0, 32'h0, "R2");
        idle("R1");

        // clear the swap register through halves
        set_mode(1);
        access(1, SWAP_DW, 0, 32'h0000_0000, "R10");
        access(1, SWAP_DW, 1, 32'h0000_0000, "R10");
        access(0, SWAP_DW, 0, 32'h0, "R10");
        access(0, SWAP_DW, 1, 32'h0, "R10");
        access(1, 16, 0, 32'h0000_C0DE, "R9");
        access(1, 16, 1, 32'h0000_F00D, "R9");
        idle("R9");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule